// File: doc/BRIEF.md
# Runahead Mode Controller

This controller decides when a small out-of-order core model leaves normal execution and runs ahead speculatively while a long-latency load is outstanding. When the oldest reorder-buffer entry is a load that missed the last-level cache, the controller raises a checkpoint-capture strobe, records the miss tag, poisons the load's destination register and enters runahead mode. It does not stall on a full window.

While runahead is active, every register read request is checked against a per-register invalid bit file. A request with any poisoned source is flagged, and its destination inherits the poison. A request whose sources are all clean clears its destination, so its memory access can proceed as a useful prefetch. Stores are suppressed for the whole episode. When a memory response carries the saved tag, a restore strobe discards all speculative work, and the whole invalid file is wiped in that same cycle.

Top module: `ra_mode_ctrl`

## Requirements
- R1: In normal mode, `head_miss_valid` high at a clock edge causes entry: `ra_active` is 1 from the next cycle on. Entry happens only through this input.
- R2: `ckpt_capture` is high for exactly the first cycle of runahead, and only then.
- R3: On entry, the bit of `inv_bits` at index `head_miss_dst` is set in the first runahead cycle.
- R4: During runahead, `rd_poisoned` is high in the same cycle when `rd_valid` is high and any source field of `rd_srcs` (field k occupies bits [k*5 +: 5] by default) indexes a set invalid bit. With `rd_dst_en` set, the bit of `rd_dst` is then 1 in the next cycle.
- R5: During runahead, a request with all sources clean gives `rd_poisoned`=0. With `rd_dst_en` set, the bit of `rd_dst` is then 0 in the next cycle.
- R6: A memory response during runahead whose tag equals the saved entry tag has three effects in the next cycle: a one-cycle `ckpt_restore`, `ra_active`=0, and all of `inv_bits` cleared.
- R7: Responses with any other tag, and all responses in normal mode, change nothing.
- R8: A further head miss during runahead raises no `ckpt_capture` and keeps the saved tag. Only its destination bit is set.
- R9: A head miss sampled while `ckpt_restore` is high is ignored. One presented in the following cycle is accepted.
- R10: `store_suppress` equals `ra_active` in every cycle. After reset, all outputs are 0.
- R11: In normal mode, read requests leave `inv_bits` unchanged and `rd_poisoned` stays 0.
- R12: When a matching response arrives in the same cycle as a read request or a head miss, the restore takes precedence and `inv_bits` is all zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_miss_valid | input | 1 | Oldest reorder-buffer entry is a load that missed the last-level cache |
| head_miss_tag | input | 6 | Miss tag of that load |
| head_miss_dst | input | 5 | Destination register of that load |
| rd_valid | input | 1 | Register read request present |
| rd_srcs | input | 10 | Packed source register indices, 5 bits each |
| rd_dst | input | 5 | Destination register of the request |
| rd_dst_en | input | 1 | Request writes a destination |
| mem_resp_valid | input | 1 | Memory response present |
| mem_resp_tag | input | 6 | Tag of the returning miss |
| ckpt_capture | output | 1 | One-cycle checkpoint-capture strobe |
| ckpt_restore | output | 1 | One-cycle checkpoint-restore strobe |
| ra_active | output | 1 | Runahead mode flag |
| store_suppress | output | 1 | Blocks architectural store updates |
| inv_bits | output | 32 | Per-register invalid bits |
| rd_poisoned | output | 1 | Current request reads a poisoned source |

## Verification
The collisions that matter are the matching memory response landing in the same cycle as a poisoned read and a second head miss, and a fresh head miss landing on the restore strobe itself. The bench drives the response, the poisoned request and the miss together. It then expects a fully clean invalid file and no mode flag, which shows that the restore beat both writers. It next presents a miss during the restore cycle and expects no capture, followed by a retried miss one cycle later that must be accepted.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [0:0] {
    MODE_NORMAL = 1'b0,
    MODE_SPEC   = 1'b1
  } mode_e;
endpackage

// File: rtl/ra_fsm.sv
module ra_fsm #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             resp_valid,
  input  logic [TAG_W-1:0] resp_tag,
  output logic             spec_active,
  output logic             capture_q,
  output logic             restore_q,
  output logic [TAG_W-1:0] saved_tag,
  output logic             enter_evt,
  output logic             exit_evt,
  output logic             extra_miss_evt
);
  import ra_pkg::*;

  mode_e            mode_q;
  logic [TAG_W-1:0] tag_q;

  function automatic logic tag_hit(input logic [TAG_W-1:0] a,
                                   input logic [TAG_W-1:0] b);
    return a == b;
  endfunction

  // a restore cycle counts as normal but blocks a fresh entry
  assign enter_evt      = (mode_q == MODE_NORMAL) && miss_valid && !restore_q;
  assign exit_evt       = (mode_q == MODE_SPEC) && resp_valid && tag_hit(resp_tag, tag_q);
  assign extra_miss_evt = (mode_q == MODE_SPEC) && miss_valid && !exit_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_NORMAL;
      capture_q <= 1'b0;
      restore_q <= 1'b0;
      tag_q     <= '0;
    end else begin
      capture_q <= enter_evt;
      restore_q <= exit_evt;
      if (exit_evt) begin
        mode_q <= MODE_NORMAL;
      end else if (enter_evt) begin
        mode_q <= MODE_SPEC;
        tag_q  <= miss_tag;
      end
    end
  end

  assign spec_active = (mode_q == MODE_SPEC);
  assign saved_tag   = tag_q;
endmodule

// File: rtl/ra_src_check.sv
module ra_src_check #(
  parameter int NREG  = 32,
  parameter int NSRC  = 2,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]       inv,
  input  logic [NSRC*IDX_W-1:0] srcs,
  output logic                  any_bad
);
  logic [NSRC-1:0] bad_per_src;

  function automatic logic [IDX_W-1:0] pick(input logic [NSRC*IDX_W-1:0] s,
                                            input int k);
    return s[k*IDX_W +: IDX_W];
  endfunction

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign bad_per_src[k] = inv[pick(srcs, k)];
  end

  assign any_bad = |bad_per_src;
endmodule

// File: rtl/ra_inv_file.sv
module ra_inv_file #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  output logic [NREG-1:0]  inv
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inv[i] <= 1'b0;
      end else if (clear_all) begin
        inv[i] <= 1'b0;
      end else if (set_en && set_idx == MY_IDX) begin
        inv[i] <= 1'b1;
      end else if (wr_en && wr_idx == MY_IDX) begin
        inv[i] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl #(
  parameter int NREG  = 32,
  parameter int NSRC  = 2,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  head_miss_valid,
  input  logic [TAG_W-1:0]      head_miss_tag,
  input  logic [IDX_W-1:0]      head_miss_dst,
  input  logic                  rd_valid,
  input  logic [NSRC*IDX_W-1:0] rd_srcs,
  input  logic [IDX_W-1:0]      rd_dst,
  input  logic                  rd_dst_en,
  input  logic                  mem_resp_valid,
  input  logic [TAG_W-1:0]      mem_resp_tag,
  output logic                  ckpt_capture,
  output logic                  ckpt_restore,
  output logic                  ra_active,
  output logic                  store_suppress,
  output logic [NREG-1:0]       inv_bits,
  output logic                  rd_poisoned
);
  logic             enter_evt, exit_evt, extra_miss_evt;
  logic [TAG_W-1:0] spec_tag;
  logic             src_bad;
  logic             spec_write;

  ra_fsm #(.TAG_W(TAG_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (head_miss_valid),
    .miss_tag       (head_miss_tag),
    .resp_valid     (mem_resp_valid),
    .resp_tag       (mem_resp_tag),
    .spec_active    (ra_active),
    .capture_q      (ckpt_capture),
    .restore_q      (ckpt_restore),
    .saved_tag      (spec_tag),
    .enter_evt      (enter_evt),
    .exit_evt       (exit_evt),
    .extra_miss_evt (extra_miss_evt)
  );

  ra_src_check #(.NREG(NREG), .NSRC(NSRC), .IDX_W(IDX_W)) u_src (
    .inv     (inv_bits),
    .srcs    (rd_srcs),
    .any_bad (src_bad)
  );

  assign rd_poisoned = ra_active && rd_valid && src_bad;
  assign spec_write  = ra_active && rd_valid && rd_dst_en;

  // restore wins over both writers; a miss poison wins over a result write
  ra_inv_file #(.NREG(NREG), .IDX_W(IDX_W)) u_inv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (exit_evt),
    .set_en    (enter_evt || extra_miss_evt),
    .set_idx   (head_miss_dst),
    .wr_en     (spec_write),
    .wr_idx    (rd_dst),
    .wr_val    (rd_poisoned),
    .inv       (inv_bits)
  );

  assign store_suppress = ra_active;
endmodule

// File: rtl/ra_mode_ctrl_chk.sv
module ra_mode_ctrl_chk #(
  parameter int NREG  = 32,
  parameter int TAG_W = 6,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             head_miss_valid,
  input logic             rd_valid,
  input logic [IDX_W-1:0] rd_dst,
  input logic             rd_dst_en,
  input logic             rd_poisoned,
  input logic             mem_resp_valid,
  input logic [TAG_W-1:0] mem_resp_tag,
  input logic             ckpt_capture,
  input logic             ckpt_restore,
  input logic             ra_active,
  input logic [NREG-1:0]  inv_bits,
  input logic [TAG_W-1:0] spec_tag,
  input logic             exit_evt
);
  a_r1_entry_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ra_active) |-> $past(head_miss_valid));

  a_r2_capture_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ra_active) |-> ckpt_capture);

  a_r8_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_capture |=> !ckpt_capture);

  a_r3_entry_poisons_one: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_capture |-> ($countones(inv_bits) == 1));

  a_r4_poison_inherits: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_active && rd_valid && rd_dst_en && rd_poisoned && !exit_evt)
      |=> inv_bits[$past(rd_dst)]);

  a_r6_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |-> (inv_bits == '0 && !ra_active));

  a_r6_exit_with_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ra_active) |-> ckpt_restore);

  a_r7_tag_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_active && !(mem_resp_valid && mem_resp_tag == spec_tag)) |=> ra_active);

  a_r9_gap_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore |=> !ckpt_capture);
endmodule

bind ra_mode_ctrl ra_mode_ctrl_chk #(.NREG(NREG), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .head_miss_valid (head_miss_valid),
  .rd_valid        (rd_valid),
  .rd_dst          (rd_dst),
  .rd_dst_en       (rd_dst_en),
  .rd_poisoned     (rd_poisoned),
  .mem_resp_valid  (mem_resp_valid),
  .mem_resp_tag    (mem_resp_tag),
  .ckpt_capture    (ckpt_capture),
  .ckpt_restore    (ckpt_restore),
  .ra_active       (ra_active),
  .inv_bits        (inv_bits),
  .spec_tag        (spec_tag),
  .exit_evt        (exit_evt)
);

// File: tb/ra_mode_ctrl_tb.sv
module ra_mode_ctrl_tb;
  localparam int NREG = 32, NSRC = 2, TAG_W = 6, IDX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_miss_valid = 0, rd_valid = 0, rd_dst_en = 0, mem_resp_valid = 0;
  logic [TAG_W-1:0] head_miss_tag = '0, mem_resp_tag = '0;
  logic [IDX_W-1:0] head_miss_dst = '0, rd_dst = '0;
  logic [NSRC*IDX_W-1:0] rd_srcs = '0;
  logic ckpt_capture, ckpt_restore, ra_active, store_suppress, rd_poisoned;
  logic [NREG-1:0] inv_bits;

  ra_mode_ctrl u_dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic            ra, cap, rest;
    logic [NREG-1:0] inv;
    string           req;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  bit done = 0;

  // reference state kept by the bench
  logic            m_ra = 0, m_rest = 0;
  logic [NREG-1:0] m_inv = '0;
  logic [TAG_W-1:0] m_tag = '0;

  task automatic check1(input string req, input string what,
                        input logic [NREG-1:0] act, input logic [NREG-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic mv, input logic [TAG_W-1:0] mtag, input logic [IDX_W-1:0] mdst,
                      input logic rv, input logic [IDX_W-1:0] s0, input logic [IDX_W-1:0] s1,
                      input logic [IDX_W-1:0] dst, input logic den,
                      input logic pv, input logic [TAG_W-1:0] ptag, input string req);
    logic pois, ex, en;
    exp_t e;
    @(negedge clk);
    head_miss_valid = mv; head_miss_tag = mtag; head_miss_dst = mdst;
    rd_valid = rv; rd_srcs = {s1, s0}; rd_dst = dst; rd_dst_en = den;
    mem_resp_valid = pv; mem_resp_tag = ptag;
    #1;
    pois = m_ra && rv && (m_inv[s0] || m_inv[s1]);
    check1(req, "rd_poisoned", NREG'(rd_poisoned), NREG'(pois));
    ex = m_ra && pv && (ptag == m_tag);
    en = !m_ra && mv && !m_rest;
    if (ex) m_inv = '0;
    else begin
      if (m_ra && rv && den) m_inv[dst] = pois;
      if (en || (m_ra && mv)) m_inv[mdst] = 1'b1;
    end
    if (en) m_tag = mtag;
    m_ra = ex ? 1'b0 : (en ? 1'b1 : m_ra);
    m_rest = ex;
    e.ra = m_ra; e.cap = en; e.rest = ex; e.inv = m_inv; e.req = req;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // monitor: compares registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check1(e.req, "ra_active", NREG'(ra_active), NREG'(e.ra));
        check1(e.req, "ckpt_capture", NREG'(ckpt_capture), NREG'(e.cap));
        check1(e.req, "ckpt_restore", NREG'(ckpt_restore), NREG'(e.rest));
        check1(e.req, "inv_bits", inv_bits, e.inv);
        check1("R10", "store_suppress", NREG'(store_suppress), NREG'(e.ra));
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R10 reset state
    check1("R10", "reset outputs",
           NREG'({ckpt_capture, ckpt_restore, ra_active, store_suppress, rd_poisoned}), '0);
    check1("R10", "reset inv", inv_bits, '0);
    step(0, 0, 0, 1, 4, 6, 8, 1, 0, 0, "R11");      // normal read: no effect
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 5, "R7");       // response in normal mode ignored
    step(1, 5, 3, 0, 0, 0, 0, 0, 0, 0, "R1_R3");    // enter on head miss
    idle("R2");                                      // capture drops after one cycle
    step(0, 0, 0, 1, 3, 0, 7, 1, 0, 0, "R4");       // poisoned source
    step(0, 0, 0, 1, 1, 2, 7, 1, 0, 0, "R5");       // clean sources clear dst
    step(0, 0, 0, 1, 0, 3, 9, 1, 0, 0, "R4");       // poison from second field
    step(0, 0, 0, 1, 9, 9, 11, 0, 0, 0, "R4");      // poisoned, no dst write
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 6, "R7");       // wrong tag
    step(1, 9, 12, 0, 0, 0, 0, 0, 0, 0, "R8");      // second miss: no capture
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 9, "R7_R8");    // second miss tag not saved
    step(1, 2, 20, 1, 12, 3, 21, 1, 1, 5, "R6_R12"); // restore collides
    step(1, 7, 4, 0, 0, 0, 0, 0, 0, 0, "R9");       // miss on restore cycle ignored
    step(1, 7, 4, 0, 0, 0, 0, 0, 0, 0, "R9_R1");    // retried miss accepted
    step(1, 8, 4, 1, 4, 0, 4, 1, 0, 0, "R8_R4");    // miss and poisoned write same reg
    step(0, 0, 0, 1, 1, 1, 4, 1, 1, 7, "R6_R12");   // exit beats clean write
    step(0, 0, 0, 1, 4, 4, 5, 1, 0, 0, "R11");      // normal read after exit
    idle("R10");
    idle("R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule